// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for every beat of a four-word burst. It latches a complete starting address on any rising clock edge at which either of two active-low address strobes is low. One strobe comes from the processor and the other from a cache controller. From then on, the two low-order address bits move to the next position of the burst on every edge at which the active-low advance input is low. The upper address bits never change within a burst.

The burst order is chosen at the strobe edge by the order-select input:
- A value of 0 gives a linear order: the start bits plus the beat count, modulo four.
- A value of 1 gives an interleaved order: the start bits XOR the beat count.

The beat count wraps, so every beat stays inside the aligned block of four words that holds the starting address. Further advance pulses keep cycling through that same block.

A memory or cache controller places this sequencer in front of the array's address decoder. The output is a function of registered state only, so it is stable for the whole cycle after each edge.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge where `cpu_stb_n` is 0, the whole of `addr_in` is captured, and from the next cycle `burst_addr` equals it exactly (beat count 0).
- R2: On a rising edge where `ctl_stb_n` is 0 and `cpu_stb_n` is 1, the controller strobe alone starts a burst in the same way as R1.
- R3: On an edge with both strobes at 1, `adv_n` at 0 moves the beat count forward by one and changes the low two bits of `burst_addr`; `adv_n` at 1 leaves `burst_addr` unchanged.
- R4: With `order_sel` 0 at the strobe edge (linear), the low two bits after k advances equal (start low bits + k) mod 4. Example: start 1 gives 1,2,3,0.
- R5: With `order_sel` 1 at the strobe edge (interleaved), the low two bits after k advances equal start low bits XOR (k mod 4). Example: start 1 gives 1,0,3,2.
- R6: While no strobe is sampled, the upper address bits (`burst_addr[ADDR_W-1:2]`) stay constant, whatever `addr_in` does.
- R7: The beat count wraps. Four advances return to the starting address, and later advances repeat the same four-word sequence without stopping.
- R8: A strobe sampled on the same edge as `adv_n` = 0 wins: the new address is loaded at beat 0 and the advance is ignored.
- R9: The burst order is latched at the strobe edge. A change of `order_sel` in mid-burst has no effect until the next strobe.
- R10: A synchronous reset (`srst_n` 0 at a rising edge) clears the beat count and the captured address, so `burst_addr` reads 0 in the next cycle. A later advance with no strobe gives address 1 in linear order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| srst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | Starting word address, captured on a strobe |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved; latched at the strobe |
| burst_addr | output | ADDR_W | Word address of the current beat |

## Verification
The bench builds the sequencer with `ADDR_W` = 12 and the default `BEAT_W` = 2. A twelve-bit address keeps the expected values short to read, while the ten upper bits can still carry non-zero patterns. Any disturbance of those upper bits during a burst, or any loss of them at capture, therefore shows up at the port. Starting addresses with low bits 1 and 2 are used in both orders, which separates the additive order from the XOR order. Runs of eight advances carry each burst through its wrap point twice.

// File: rtl/bas_pkg.sv
package bas_pkg;

    // Burst ordering selected at the strobe edge
    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/bas_start_reg.sv
// Holds the starting address and the burst order of the active burst.
module bas_start_reg #(
    parameter int ADDR_W = 17
) (
    input  logic               clk,
    input  logic               srst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  addr_in,
    input  bas_pkg::order_e    order_in,
    output logic [ADDR_W-1:0]  start_addr,
    output bas_pkg::order_e    order_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        bas_pkg::order_e   order;
    } start_t;

    start_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.addr  = addr_in;
            st_d.order = order_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!srst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_addr = st_q.addr;
    assign order_q    = st_q.order;

endmodule

// File: rtl/bas_beat_ctr.sv
// Wrapping beat counter: cleared by a load, stepped by an advance.
module bas_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    typedef struct packed {
        logic [BEAT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.cnt = '0;                    // strobe wins over advance
        end else if (step) begin
            ctr_d.cnt = ctr_q.cnt + BEAT_ONE;  // natural wrap
        end
    end

    always_ff @(posedge clk) begin
        if (!srst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign beat = ctr_q.cnt;

endmodule

// File: rtl/bas_order_map.sv
// Maps start low bits and beat count to the beat's low address bits.
module bas_order_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    input  bas_pkg::order_e   order,
    output logic [BEAT_W-1:0] low_out
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] int_low;

    assign lin_low = start_low + beat;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
        assign int_low[b] = start_low[b] ^ beat[b];
    end

    always_comb begin
        unique case (order)
            bas_pkg::ORDER_INTERLEAVE: low_out = int_low;
            default:                   low_out = lin_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer: top level.
module burst_addr_seq #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] burst_addr
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic              load;
    logic              step;
    logic [ADDR_W-1:0] start_addr;
    bas_pkg::order_e   order_q;
    bas_pkg::order_e   order_in;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low_bits;

    // Either strobe starts a burst; advance only counts without a strobe.
    assign load     = ~cpu_stb_n | ~ctl_stb_n;
    assign step     = ~adv_n;
    assign order_in = bas_pkg::order_e'(order_sel);

    bas_start_reg #(.ADDR_W(ADDR_W)) i_start (
        .clk        (clk),
        .srst_n     (srst_n),
        .load       (load),
        .addr_in    (addr_in),
        .order_in   (order_in),
        .start_addr (start_addr),
        .order_q    (order_q)
    );

    bas_beat_ctr #(.BEAT_W(BEAT_W)) i_ctr (
        .clk    (clk),
        .srst_n (srst_n),
        .load   (load),
        .step   (step),
        .beat   (beat)
    );

    bas_order_map #(.BEAT_W(BEAT_W)) i_map (
        .start_low (start_addr[BEAT_W-1:0]),
        .beat      (beat),
        .order     (order_q),
        .low_out   (low_bits)
    );

    logic [UPPER_W-1:0] upper_bits;
    assign upper_bits = start_addr[ADDR_W-1:BEAT_W];
    assign burst_addr = {upper_bits, low_bits};

endmodule

// File: rtl/bas_chk.sv
// Property checker for the burst address sequencer.
module bas_chk #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              srst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              cpu_stb_n,
    input logic              ctl_stb_n,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] burst_addr
);

    logic seen_q = 1'b0;
    always_ff @(posedge clk) seen_q <= 1'b1;

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        (seen_q && !$past(srst_n)) |-> (burst_addr == '0));

    // R1
    cpu_capture_chk: assert property (@(posedge clk) disable iff (!srst_n)
        !cpu_stb_n |=> (burst_addr == $past(addr_in)));

    // R2
    ctl_capture_chk: assert property (@(posedge clk) disable iff (!srst_n)
        !ctl_stb_n |=> (burst_addr == $past(addr_in)));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
        (cpu_stb_n && ctl_stb_n && adv_n) |=> $stable(burst_addr));

    // R3
    advance_moves_chk: assert property (@(posedge clk) disable iff (!srst_n)
        (cpu_stb_n && ctl_stb_n && !adv_n)
        |=> (burst_addr[BEAT_W-1:0] != $past(burst_addr[BEAT_W-1:0])));

    // R6
    upper_const_chk: assert property (@(posedge clk) disable iff (!srst_n)
        (cpu_stb_n && ctl_stb_n)
        |=> $stable(burst_addr[ADDR_W-1:BEAT_W]));

    // R8
    strobe_priority_chk: assert property (@(posedge clk) disable iff (!srst_n)
        ((!cpu_stb_n || !ctl_stb_n) && !adv_n)
        |=> (burst_addr == $past(addr_in)));

    logic unused_ok;
    assign unused_ok = order_sel;

endmodule

bind burst_addr_seq bas_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_bas_chk (
    .clk        (clk),
    .srst_n     (srst_n),
    .addr_in    (addr_in),
    .cpu_stb_n  (cpu_stb_n),
    .ctl_stb_n  (ctl_stb_n),
    .adv_n      (adv_n),
    .order_sel  (order_sel),
    .burst_addr (burst_addr)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    localparam int AW = 12;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          srst_n;
    logic [AW-1:0] addr_in;
    logic          cpu_stb_n;
    logic          ctl_stb_n;
    logic          adv_n;
    logic          order_sel;
    logic [AW-1:0] burst_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_seq (
        .clk        (clk),
        .srst_n     (srst_n),
        .addr_in    (addr_in),
        .cpu_stb_n  (cpu_stb_n),
        .ctl_stb_n  (ctl_stb_n),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .burst_addr (burst_addr)
    );

    // Expected address of beat k, from R4 and R5
    function automatic logic [AW-1:0] model(logic [AW-1:0] s, int k, bit inter);
        logic [BW-1:0] lo;
        logic [BW-1:0] kb;
        lo = s[BW-1:0];
        kb = BW'(k);
        return {s[AW-1:BW], inter ? (lo ^ kb) : (lo + kb)};
    endfunction

    task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        cpu_stb_n = 1'b1;
        ctl_stb_n = 1'b1;
        adv_n     = 1'b1;
    endtask

    task automatic start_burst(logic [AW-1:0] a, bit use_ctl, bit inter, string req);
        addr_in   = a;
        order_sel = inter;
        adv_n     = 1'b1;
        if (use_ctl) ctl_stb_n = 1'b0;
        else         cpu_stb_n = 1'b0;
        step();
        go_idle();
        chk(req, burst_addr, a);
    endtask

    task automatic advance_and_check(logic [AW-1:0] s, int k, bit inter, string req);
        adv_n = 1'b0;
        step();
        adv_n = 1'b1;
        chk(req, burst_addr, model(s, k, inter));
    endtask

    task automatic t_reset();
        srst_n = 1'b0;
        step();
        chk("R10 reset value", burst_addr, '0);
        srst_n = 1'b1;
    endtask

    task automatic t_linear();
        logic [AW-1:0] s = 12'hA51;
        start_burst(s, 1'b0, 1'b0, "R1 cpu strobe capture");
        for (int k = 1; k <= 8; k++)
            advance_and_check(s, k, 1'b0, k < 4 ? "R4 linear beat" : "R7 linear wrap");
    endtask

    task automatic t_interleave();
        logic [AW-1:0] s = 12'h3C5;
        start_burst(s, 1'b0, 1'b1, "R1 cpu strobe capture");
        for (int k = 1; k <= 8; k++)
            advance_and_check(s, k, 1'b1, k < 4 ? "R5 interleaved beat" : "R7 interleaved wrap");
    endtask

    task automatic t_ctl_strobe();
        logic [AW-1:0] s = 12'h7F2;
        start_burst(s, 1'b1, 1'b1, "R2 controller strobe capture");
        for (int k = 1; k <= 4; k++)
            advance_and_check(s, k, 1'b1, "R5 interleaved from start 2");
        start_burst(12'h0B6, 1'b1, 1'b0, "R2 controller strobe capture");
        for (int k = 1; k <= 4; k++)
            advance_and_check(12'h0B6, k, 1'b0, "R4 linear from start 2");
    endtask

    task automatic t_hold_and_upper();
        logic [AW-1:0] s = 12'h5A9;
        start_burst(s, 1'b0, 1'b0, "R1 cpu strobe capture");
        advance_and_check(s, 1, 1'b0, "R3 advance steps");
        for (int i = 0; i < 3; i++) begin
            addr_in = 12'hFFF - 12'(i);
            step();
            chk("R3 hold without advance", burst_addr, model(s, 1, 1'b0));
        end
        addr_in = 12'h000;
        for (int k = 2; k <= 5; k++) begin
            advance_and_check(s, k, 1'b0, "R6 upper bits kept");
            chk("R6 upper bits kept", {burst_addr[AW-1:BW], 2'b00}, {s[AW-1:BW], 2'b00});
        end
    endtask

    task automatic t_priority();
        logic [AW-1:0] s = 12'h111;
        logic [AW-1:0] n = 12'hC4E;
        start_burst(s, 1'b0, 1'b0, "R1 cpu strobe capture");
        advance_and_check(s, 1, 1'b0, "R4 linear beat");
        addr_in   = n;
        order_sel = 1'b1;
        cpu_stb_n = 1'b0;
        adv_n     = 1'b0;
        step();
        go_idle();
        chk("R8 strobe beats advance", burst_addr, n);
        advance_and_check(n, 1, 1'b1, "R8 new burst beat 1");
    endtask

    task automatic t_mode_latch();
        logic [AW-1:0] s = 12'h2E1;
        start_burst(s, 1'b0, 1'b0, "R1 cpu strobe capture");
        order_sel = 1'b1;
        for (int k = 1; k <= 3; k++)
            advance_and_check(s, k, 1'b0, "R9 order held mid-burst");
        start_burst(s, 1'b0, 1'b1, "R1 cpu strobe capture");
        order_sel = 1'b0;
        for (int k = 1; k <= 3; k++)
            advance_and_check(s, k, 1'b1, "R9 order held mid-burst");
    endtask

    task automatic t_reset_mid();
        logic [AW-1:0] s = 12'h9D3;
        start_burst(s, 1'b0, 1'b1, "R1 cpu strobe capture");
        advance_and_check(s, 1, 1'b1, "R5 interleaved beat");
        srst_n = 1'b0;
        adv_n  = 1'b0;
        step();
        chk("R10 reset mid-burst", burst_addr, '0);
        srst_n = 1'b1;
        step();
        adv_n = 1'b1;
        chk("R10 count restarts after reset", burst_addr, 12'h001);
    endtask

    initial begin
        srst_n    = 1'b0;
        addr_in   = '0;
        order_sel = 1'b0;
        go_idle();
        @(negedge clk);
        t_reset();
        t_linear();
        t_interleave();
        t_ctl_strobe();
        t_hold_and_upper();
        t_priority();
        t_mode_latch();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule